// File: doc/BRIEF.md
# Non-Posted Request Queue

This block buffers non-posted requests (memory reads, I/O or configuration reads, I/O writes and configuration writes) that arrive from a serial link. It hands them in strict arrival order to the master on the internal bus. Every entry is one four-doubleword slot. A request that carries data always has a three-doubleword header and exactly one doubleword of payload. That payload travels in the fourth doubleword of the slot, so the queue needs no separate data store. Each stored entry carries a has-data flag, so the reader knows whether doubleword 3 is payload or header.

The link side pushes through a valid/ready handshake, and a transfer takes place on a clock edge where both are high. `in_ready` is high whenever the queue is not full. It is also high while the queue is full if the reader pops in the same cycle. The reader side is a valid/ready handshake too. `out_valid` stays high while the queue holds anything. The head entry does not change while the reader holds `out_ready` low. When a request that carries data has the wrong header size or length, the queue still accepts it on the link side but does not store it, and it reports the drop on `malformed`. Each pop returns one header credit to the link through a one-cycle pulse on `credit_rel`.

Top module: `np_req_queue`

## Requirements
- R1: While reset is held and on the first cycle after it, `empty`=1, `full`=0, `out_valid`=0, `malformed`=0 and `credit_rel`=0.
- R2: Entries leave in the order they were accepted, with `out_slot` and `out_kind` equal to the values given at push.
- R3: The queue holds DEPTH entries (default 8). `full`=1 exactly when DEPTH entries are stored. In that state `in_ready` is 0 unless `out_ready` is 1 in the same cycle, and a push offered while `in_ready`=0 is not stored.
- R4: `full` and `empty` are registered. They take their new value on the clock edge that completes the push or pop. `out_valid` equals the inverse of `empty`.
- R5: When the queue is full, a push and a pop in the same cycle both complete, and `full` stays 1.
- R6: Kind codes are 00 memory read, 01 I/O or configuration read, 10 I/O write and 11 configuration write. `out_has_data` is 1 exactly for codes 10 and 11. For those codes, doubleword 3 (`out_slot[127:96]`) is the payload as supplied.
- R7: A push with kind 10 or 11 whose `in_hdr_dw` is not 3, or whose `in_len` is not 1, is accepted and not stored. `malformed` pulses high for one cycle on the cycle after the acceptance. Reads are never flagged as malformed.
- R8: `credit_rel` is high for exactly one cycle, on the cycle after each pop handshake, and at no other time.
- R9: While `out_valid`=1 and `out_ready`=0, `out_slot`, `out_kind` and `out_has_data` hold their values on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Link side offers a request |
| in_ready | output | 1 | Queue can take the request this cycle |
| in_kind | input | 2 | Request kind code (see R6) |
| in_hdr_dw | input | HDR_W (3) | Header size in doublewords |
| in_len | input | LEN_W (10) | Payload length in doublewords |
| in_slot | input | 128 | Four doublewords; DW0 in bits 31:0 |
| out_valid | output | 1 | Head entry available |
| out_ready | input | 1 | Internal master takes the head entry |
| out_kind | output | 2 | Kind code of the head entry |
| out_has_data | output | 1 | Doubleword 3 of the head holds payload |
| out_slot | output | 128 | Head entry slot |
| full | output | 1 | Registered full flag |
| empty | output | 1 | Registered empty flag |
| malformed | output | 1 | One-cycle pulse: a write request was dropped |
| credit_rel | output | 1 | One-cycle pulse: one header credit returned |

## Verification
`in_ready` and the head outputs are combinational from state and `out_ready`. The bench therefore samples them two time units after it drives inputs, before the edge that completes the handshake. `full`, `empty`, `malformed` and `credit_rel` change on the edge that completes the handshake, so each is sampled one time unit after that edge and compared with a bench queue model advanced by the same handshake. Stalled cycles compare the head slot with the value seen on the cycle before.

// File: rtl/npq_pkg.sv
package npq_pkg;
  localparam int DW_W        = 32;
  localparam int SLOT_DW     = 4;
  localparam int SLOT_W      = DW_W * SLOT_DW;
  localparam int DATA_HDR_DW = 3;
  localparam int DATA_LEN_DW = 1;

  typedef enum logic [1:0] {
    NPK_MEM_RD   = 2'b00,
    NPK_OTHER_RD = 2'b01,
    NPK_IO_WR    = 2'b10,
    NPK_CFG_WR   = 2'b11
  } np_kind_e;

  typedef struct packed {
    np_kind_e            kind;
    logic                has_data;
    logic [SLOT_W-1:0]   slot;
  } np_entry_t;
endpackage

// File: rtl/np_req_classify.sv
module np_req_classify
  import npq_pkg::*;
#(
  parameter int LEN_W = 10,
  parameter int HDR_W = 3
) (
  input  np_kind_e          kind,
  input  logic [HDR_W-1:0]  hdr_dw,
  input  logic [LEN_W-1:0]  len,
  output logic              carries_data,
  output logic              bad_shape
);
  localparam logic [HDR_W-1:0] HDR_OK = HDR_W'(DATA_HDR_DW);
  localparam logic [LEN_W-1:0] LEN_OK = LEN_W'(DATA_LEN_DW);

  always_comb begin
    unique case (kind)
      NPK_IO_WR, NPK_CFG_WR: carries_data = 1'b1;
      default:               carries_data = 1'b0;
    endcase
    bad_shape = carries_data && ((hdr_dw != HDR_OK) || (len != LEN_OK));
  end
endmodule

// File: rtl/np_slot_store.sv
module np_slot_store
  import npq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  np_entry_t  din,
  input  logic       pop,
  output np_entry_t  dout,
  output logic       full_q,
  output logic       empty_q
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam bit POW2  = (DEPTH > 1) && ((DEPTH & (DEPTH - 1)) == 0);

  np_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_inc, rd_inc;
  logic [CNT_W-1:0] cnt, cnt_n;

  generate
    if (POW2) begin : g_pow2
      assign wr_inc = wr_ptr + PTR_W'(1);
      assign rd_inc = rd_ptr + PTR_W'(1);
    end else begin : g_wrap
      assign wr_inc = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      assign rd_inc = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
    end
  endgenerate

  assign cnt_n = cnt + CNT_W'(push) - CNT_W'(pop);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt     <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      if (push) wr_ptr <= wr_inc;
      if (pop)  rd_ptr <= rd_inc;
      cnt     <= cnt_n;
      full_q  <= (cnt_n == CNT_W'(DEPTH));
      empty_q <= (cnt_n == '0);
    end
  end
endmodule

// File: rtl/np_credit_ret.sv
module np_credit_ret (
  input  logic clk,
  input  logic rst_n,
  input  logic popped,
  input  logic dropped,
  output logic credit_q,
  output logic drop_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      credit_q <= 1'b0;
      drop_q   <= 1'b0;
    end else begin
      credit_q <= popped;
      drop_q   <= dropped;
    end
  end
endmodule

// File: rtl/np_req_queue.sv
module np_req_queue
  import npq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LEN_W = 10,
  parameter int HDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_kind,
  input  logic [HDR_W-1:0]  in_hdr_dw,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [SLOT_W-1:0] in_slot,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_kind,
  output logic              out_has_data,
  output logic [SLOT_W-1:0] out_slot,
  output logic              full,
  output logic              empty,
  output logic              malformed,
  output logic              credit_rel
);
  np_kind_e  kind_in;
  logic      carries_data, bad_shape;
  logic      accept, push, pop;
  np_entry_t wr_entry, rd_entry;

  assign kind_in = np_kind_e'(in_kind);

  np_req_classify #(.LEN_W(LEN_W), .HDR_W(HDR_W)) u_cls (
    .kind         (kind_in),
    .hdr_dw       (in_hdr_dw),
    .len          (in_len),
    .carries_data (carries_data),
    .bad_shape    (bad_shape)
  );

  assign out_valid = !empty;
  assign pop       = out_valid && out_ready;
  assign in_ready  = !full || pop;
  assign accept    = in_valid && in_ready;
  assign push      = accept && !bad_shape;

  always_comb begin
    wr_entry.kind     = kind_in;
    wr_entry.has_data = carries_data;
    wr_entry.slot     = in_slot;
  end

  np_slot_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (push),
    .din     (wr_entry),
    .pop     (pop),
    .dout    (rd_entry),
    .full_q  (full),
    .empty_q (empty)
  );

  assign out_kind     = rd_entry.kind;
  assign out_has_data = rd_entry.has_data;
  assign out_slot     = rd_entry.slot;

  np_credit_ret u_cred (
    .clk      (clk),
    .rst_n    (rst_n),
    .popped   (pop),
    .dropped  (accept && bad_shape),
    .credit_q (credit_rel),
    .drop_q   (malformed)
  );
endmodule

// File: rtl/np_req_queue_chk.sv
module np_req_queue_chk
  import npq_pkg::*;
#(
  parameter int LEN_W = 10,
  parameter int HDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        in_kind,
  input logic [HDR_W-1:0]  in_hdr_dw,
  input logic [LEN_W-1:0]  in_len,
  input logic              out_valid,
  input logic              out_ready,
  input logic [1:0]        out_kind,
  input logic              out_has_data,
  input logic [SLOT_W-1:0] out_slot,
  input logic              full,
  input logic              empty,
  input logic              malformed,
  input logic              credit_rel
);
  logic req_bad, req_take, req_pop;
  assign req_bad  = in_kind[1] && ((in_hdr_dw != HDR_W'(3)) || (in_len != LEN_W'(1)));
  assign req_take = in_valid && in_ready;
  assign req_pop  = out_valid && out_ready;

  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (empty && !full && !out_valid && !malformed && !credit_rel));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !out_ready) |-> !in_ready);

  a_r4_push_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && req_take && !req_bad) |=> (out_valid && !empty));

  a_r5_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (full && req_take && !req_bad && req_pop) |=> full);

  a_r6_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_has_data == out_kind[1]));

  a_r7_drop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (req_take && req_bad) |=> malformed);

  a_r7_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    malformed |-> $past(req_take && req_bad));

  a_r8_credit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_pop |=> credit_rel);

  a_r8_credit_cause: assert property (@(posedge clk) disable iff (!rst_n)
    credit_rel |-> $past(req_pop));

  a_r9_hold_head: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_slot) && $stable(out_kind)));
endmodule

bind np_req_queue np_req_queue_chk #(.LEN_W(LEN_W), .HDR_W(HDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_kind      (in_kind),
  .in_hdr_dw    (in_hdr_dw),
  .in_len       (in_len),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_kind     (out_kind),
  .out_has_data (out_has_data),
  .out_slot     (out_slot),
  .full         (full),
  .empty        (empty),
  .malformed    (malformed),
  .credit_rel   (credit_rel)
);

// File: tb/np_req_queue_tb.sv
`timescale 1ns/1ps
module np_req_queue_tb;
  import npq_pkg::*;
  localparam int DEPTH = 8;
  localparam int MQ    = 1024;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0, in_ready;
  logic [1:0]        in_kind = '0;
  logic [2:0]        in_hdr_dw = '0;
  logic [9:0]        in_len = '0;
  logic [SLOT_W-1:0] in_slot = '0;
  logic              out_valid, out_ready = 1'b0;
  logic [1:0]        out_kind;
  logic              out_has_data;
  logic [SLOT_W-1:0] out_slot;
  logic              full, empty, malformed, credit_rel;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [1:0]        mk [MQ];
  logic [SLOT_W-1:0] ms [MQ];
  int head = 0, tail = 0;
  bit stalled = 0;
  logic [SLOT_W-1:0] prev_slot = '0;

  always #10 clk = ~clk;

  np_req_queue u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_hdr_dw(in_hdr_dw), .in_len(in_len), .in_slot(in_slot),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_has_data(out_has_data), .out_slot(out_slot), .full(full), .empty(empty),
    .malformed(malformed), .credit_rel(credit_rel)
  );

  task automatic check(input bit ok, input string req,
                       input logic [SLOT_W-1:0] act, input logic [SLOT_W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [SLOT_W-1:0] mk_slot(input int i);
    logic [SLOT_W-1:0] s;
    for (int w = 0; w < SLOT_DW; w++) s[w*DW_W +: DW_W] = 32'hA500_0000 + 32'(i * 16 + w);
    return s;
  endfunction

  // Called at posedge+1; returns at the next posedge+1.
  task automatic step(input bit v, input logic [1:0] k, input logic [2:0] h,
                      input logic [9:0] l, input logic [SLOT_W-1:0] s, input bit r);
    bit acc, bad, pop, exp_rdy;
    int cnt;
    in_valid = v; in_kind = k; in_hdr_dw = h; in_len = l; in_slot = s; out_ready = r;
    #2;
    cnt = tail - head;
    bad = k[1] && (h != 3'd3 || l != 10'd1);
    exp_rdy = (cnt < DEPTH) || (r && cnt > 0);
    check(in_ready == exp_rdy, "R3 in_ready", SLOT_W'(in_ready), SLOT_W'(exp_rdy));
    check(out_valid == (cnt > 0), "R4 out_valid", SLOT_W'(out_valid), SLOT_W'(cnt > 0));
    if (cnt > 0) begin
      check(out_slot == ms[head % MQ], "R2 slot", out_slot, ms[head % MQ]);
      check(out_kind == mk[head % MQ], "R2 kind", SLOT_W'(out_kind), SLOT_W'(mk[head % MQ]));
      check(out_has_data == mk[head % MQ][1], "R6 has_data",
            SLOT_W'(out_has_data), SLOT_W'(mk[head % MQ][1]));
      if (stalled) check(out_slot == prev_slot, "R9 hold", out_slot, prev_slot);
    end
    acc = v && in_ready;
    pop = out_valid && r;
    stalled = out_valid && !r;
    prev_slot = out_slot;
    @(posedge clk); #1;
    if (pop) head++;
    if (acc && !bad) begin
      mk[tail % MQ] = k; ms[tail % MQ] = s; tail++;
    end
    cnt = tail - head;
    check(malformed == (acc && bad), "R7 malformed", SLOT_W'(malformed), SLOT_W'(acc && bad));
    check(credit_rel == pop, "R8 credit", SLOT_W'(credit_rel), SLOT_W'(pop));
    check(full == (cnt == DEPTH), "R3 full", SLOT_W'(full), SLOT_W'(cnt == DEPTH));
    check(empty == (cnt == 0), "R4 empty", SLOT_W'(empty), SLOT_W'(cnt == 0));
    in_valid = 0; out_ready = 0;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL R2 watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    int n;
    repeat (3) @(posedge clk);
    #1;
    // R1: state while reset is held
    check(empty == 1 && full == 0 && out_valid == 0 && malformed == 0 && credit_rel == 0,
          "R1 in reset", {empty, full, out_valid, malformed, credit_rel}, 5'b10000);
    rst_n = 1;
    @(posedge clk); #1;
    check(empty == 1 && full == 0 && out_valid == 0 && malformed == 0 && credit_rel == 0,
          "R1 after reset", {empty, full, out_valid, malformed, credit_rel}, 5'b10000);

    // Fill with every kind; writes use the legal 3 DW / 1 DW shape (R6 payload in DW3).
    for (int i = 0; i < DEPTH; i++) begin
      logic [1:0] k = 2'(i % 4);
      step(1, k, k[1] ? 3'd3 : 3'(3 + i % 2), k[1] ? 10'd1 : 10'(i + 1), mk_slot(i), 0);
    end
    check(full == 1, "R3 full after DEPTH pushes", SLOT_W'(full), 1);
    // Push offered while full without pop must not be stored (R3)
    step(1, 2'b00, 3'd3, 10'd4, mk_slot(100), 0);
    // R5: push and pop together while full
    step(1, 2'b10, 3'd3, 10'd1, mk_slot(8), 1);
    check(full == 1, "R5 full kept", SLOT_W'(full), 1);
    // R9: stall with head waiting
    repeat (3) step(0, 2'b00, 3'd3, 10'd0, '0, 0);
    // Drain: order, kinds and payload (R2, R6)
    while (tail - head > 0) step(0, 2'b00, 3'd3, 10'd0, '0, 1);
    check(empty == 1, "R4 empty after drain", SLOT_W'(empty), 1);

    // R7: shape sweep over writes
    n = 200;
    for (int k = 2; k < 4; k++)
      for (int h = 2; h < 5; h++)
        for (int l = 0; l < 3; l++) begin
          step(1, 2'(k), 3'(h), 10'(l), mk_slot(n), 1);
          n++;
        end
    // Reads of any shape are stored (R7)
    for (int k = 0; k < 2; k++)
      for (int h = 3; h < 5; h++)
        for (int l = 0; l < 4; l++) begin
          step(1, 2'(k), 3'(h), 10'(l), mk_slot(n), (l % 2) == 1);
          n++;
        end
    while (tail - head > 0) step(0, 2'b00, 3'd3, 10'd0, '0, 1);

    // Mixed traffic near full and empty (R2, R3, R5, R8, R9)
    seed = 32'h1234_5678;
    for (int c = 0; c < 400; c++) begin
      bit v, r;
      logic [1:0] k;
      seed = seed * 32'd1103515245 + 32'd12345;
      v = seed[20] | seed[21];
      r = (c < 200) ? (seed[22] & seed[23]) : (seed[22] | seed[24]);
      k = seed[26:25];
      step(v, k, seed[27] ? 3'd3 : 3'd4, seed[28] ? 10'd1 : 10'd2, mk_slot(n), r);
      n++;
    end
    while (tail - head > 0) step(0, 2'b00, 3'd3, 10'd0, '0, 1);
    check(empty == 1 && full == 0, "R4 final empty", {empty, full}, 2'b10);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule